// File: doc/BRIEF.md
# Block-Cipher Encryption Subkey Expander

This block turns a 128-bit user key into the fifty-two 16-bit encryption subkeys used by a 64-bit block cipher built from mixed 16-bit operations (multiplication modulo 2^16+1, addition modulo 2^16 and XOR). The key arrives as 16 bytes, with the first byte in the most significant position of `key_in`. A one-cycle `start` pulse loads the key. The block then offers the subkeys on a valid/ready output stream, in the order the cipher datapath consumes them. Each offered word carries its position, 0 to 51.

The schedule works in groups of eight words. The first group is the key itself, cut into eight 16-bit words with the most significant word first. After each group, a 128-bit key register is rotated left by 25 bits, and the next group is read from it in the same way. Six rotations take place. The sixth rotated group is cut short after its fourth word, so the stream ends at 52 words. After the last word is accepted, a single-cycle `done` pulse follows.

Back-pressure rules: a word is transferred in a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the block holds `out_index` and `out_data` unchanged. The consumer may hold `out_ready` low for any number of cycles. The only exception is a new `start`: it abandons the current stream and restarts it.

Top module: `idea_ks_gen`

## Requirements
- R1: After a synchronous reset, `out_valid` and `done` are low.
- R2: In the cycle after a `start` pulse, `out_valid` is high, `out_index` is 0, and `out_data` equals `key_in[127:112]` as sampled with `start`.
- R3: Subkeys 0 to 7 are the loaded key's eight 16-bit words, most significant first: subkey w equals `key[127-16w -: 16]`.
- R4: Subkey n, for n from 8 to 51, equals word (n mod 8) of the key rotated left by 25·floor(n/8) bits, with words numbered from the most significant end.
- R5: `out_index` starts at 0 and increases by exactly one per accepted word. It never exceeds 51, and exactly 52 words are transferred per run.
- R6: While `out_valid` is high and `out_ready` is low, and no `start` arrives, `out_valid`, `out_index` and `out_data` keep their values into the next cycle.
- R7: `done` is high for exactly one cycle, namely the cycle after word 51 is accepted. In that cycle `out_valid` is low.
- R8: A `start` during a run abandons that run. In the next cycle the stream restarts at index 0 with the new key's words.
- R9: While idle, `out_ready` has no effect: `out_valid` and `done` stay low until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that loads `key_in` and (re)starts the stream |
| key_in | input | 128 | User key; first byte in bits 127:120 |
| out_valid | output | 1 | A subkey is offered |
| out_ready | input | 1 | The consumer accepts the offered subkey |
| out_index | output | 6 | Position of the offered subkey, 0 to 51 |
| out_data | output | 16 | Offered subkey |
| done | output | 1 | One-cycle pulse after the last subkey is accepted |

## Verification
The bench builds the block with its default parameters: a 128-bit key, 16-bit words, a 25-bit rotation and 52 subkeys. These values bring all six rotations and the truncated final group within reach. Keys include all-zero, all-ones, a counting pattern and seeded random values. The consumer's ready line is random, with stall rates from none to heavy, so held words are compared across stalls. A mid-stream restart and idle ready activity are also covered.

// File: rtl/idea_ks_pkg.sv
package idea_ks_pkg;
  typedef enum logic {KS_IDLE = 1'b0, KS_RUN = 1'b1} ks_state_e;
endpackage

// File: rtl/idea_ks_keyreg.sv
module idea_ks_keyreg #(
  parameter int KEY_W  = 128,
  parameter int WORD_W = 16,
  parameter int ROT    = 25,
  localparam int GRP   = KEY_W / WORD_W,
  localparam int POS_W = $clog2(GRP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [KEY_W-1:0]  key_in,
  input  logic              rot_en,
  input  logic [POS_W-1:0]  sel,
  output logic [WORD_W-1:0] word_out
);
  logic [KEY_W-1:0]  kreg;
  logic [KEY_W-1:0]  kreg_rot;
  logic [WORD_W-1:0] words [GRP];

  // whole-register left rotate as pure wiring
  assign kreg_rot = {kreg[KEY_W-1-ROT:0], kreg[KEY_W-1 -: ROT]};

  always_ff @(posedge clk) begin
    if (rst)         kreg <= '0;
    else if (load)   kreg <= key_in;
    else if (rot_en) kreg <= kreg_rot;
  end

  // word 0 is the most significant slice
  for (genvar i = 0; i < GRP; i++) begin : g_slice
    assign words[i] = kreg[KEY_W-1-i*WORD_W -: WORD_W];
  end

  assign word_out = words[sel];
endmodule

// File: rtl/idea_ks_ctrl.sv
module idea_ks_ctrl
  import idea_ks_pkg::*;
#(
  parameter int NUM_SUB = 52,
  parameter int GRP     = 8,
  localparam int IDX_W  = $clog2(NUM_SUB),
  localparam int POS_W  = $clog2(GRP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             ready,
  output logic             valid,
  output logic [IDX_W-1:0] index,
  output logic [POS_W-1:0] pos,
  output logic             rot_en,
  output logic             done
);
  ks_state_e  state;
  logic       fire, last, grp_end;

  assign valid   = (state == KS_RUN);
  assign fire    = valid && ready;
  assign last    = (index == IDX_W'(NUM_SUB - 1));
  assign grp_end = (pos == POS_W'(GRP - 1));
  assign rot_en  = fire && grp_end && !last && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= KS_IDLE;
      index <= '0;
      pos   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state <= KS_RUN;
        index <= '0;
        pos   <= '0;
      end else if (fire) begin
        if (last) begin
          state <= KS_IDLE;
          done  <= 1'b1;
        end else begin
          index <= index + 1'b1;
          pos   <= grp_end ? '0 : pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/idea_ks_gen.sv
module idea_ks_gen #(
  parameter int KEY_W   = 128,
  parameter int WORD_W  = 16,
  parameter int ROT     = 25,
  parameter int NUM_SUB = 52
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [KEY_W-1:0]           key_in,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [$clog2(NUM_SUB)-1:0] out_index,
  output logic [WORD_W-1:0]          out_data,
  output logic                       done
);
  localparam int GRP   = KEY_W / WORD_W;
  localparam int POS_W = $clog2(GRP);

  logic [POS_W-1:0] pos;
  logic             rot_en;

  idea_ks_ctrl #(.NUM_SUB(NUM_SUB), .GRP(GRP)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .ready(out_ready),
    .valid(out_valid), .index(out_index), .pos(pos),
    .rot_en(rot_en), .done(done)
  );

  idea_ks_keyreg #(.KEY_W(KEY_W), .WORD_W(WORD_W), .ROT(ROT)) key_i (
    .clk(clk), .rst(rst), .load(start), .key_in(key_in),
    .rot_en(rot_en), .sel(pos), .word_out(out_data)
  );
endmodule

// File: rtl/idea_ks_chk.sv
module idea_ks_chk #(
  parameter int WORD_W  = 16,
  parameter int NUM_SUB = 52,
  localparam int IDX_W  = $clog2(NUM_SUB)
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              out_valid,
  input logic              out_ready,
  input logic [IDX_W-1:0]  out_index,
  input logic [WORD_W-1:0] out_data,
  input logic              done
);
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !out_valid && !done);

  a_r2_start_opens: assert property (@(posedge clk) disable iff (rst)
    start |=> out_valid && out_index == '0);

  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !start && out_index != IDX_W'(NUM_SUB - 1)
      |=> out_valid && out_index == IDX_W'($past(out_index) + 1'b1));

  a_r5_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_index < IDX_W'(NUM_SUB));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !start
      |=> out_valid && $stable(out_index) && $stable(out_data));

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !start && out_index == IDX_W'(NUM_SUB - 1)
      |=> done && !out_valid);

  a_r7_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_valid && !start |=> !out_valid);
endmodule

bind idea_ks_gen idea_ks_chk #(.WORD_W(WORD_W), .NUM_SUB(NUM_SUB)) chk_i (
  .clk(clk), .rst(rst), .start(start), .out_valid(out_valid),
  .out_ready(out_ready), .out_index(out_index), .out_data(out_data),
  .done(done)
);

// File: tb/idea_ks_gen_tb_top.sv
module idea_ks_gen_tb_top;
  localparam int NSUB = 52;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] key_in = '0;
  logic         out_ready = 1'b0;
  logic         out_valid, done;
  logic [5:0]   out_index;
  logic [15:0]  out_data;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  idea_ks_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .key_in(key_in),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_index(out_index), .out_data(out_data), .done(done)
  );

  function automatic logic [15:0] ref_sub(logic [127:0] k, int n);
    logic [127:0] r = k;
    for (int g = 0; g < n / 8; g++) r = {r[102:0], r[127:103]};
    return r[127 - 16 * (n % 8) -: 16];
  endfunction

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_key(logic [127:0] k, int stall_pct, int limit);
    int  n = 0;
    bit  stalled = 0;
    bit  rdy;
    string tag;
    @(negedge clk);
    start = 1'b1; key_in = k; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0; key_in = ~k;
    while (n < limit) begin
      rdy = (($urandom % 100) >= stall_pct);
      out_ready = rdy;
      tag = (n == 0) ? "R2/R8" : (stalled ? "R6" : "R5");
      chk(out_valid === 1'b1 && out_index == 6'(n), tag,
          {out_valid, out_index}, {1'b1, 6'(n)});
      tag = (n == 0) ? "R2/R8" : (stalled ? "R6" : (n < 8 ? "R3" : "R4"));
      chk(out_data == ref_sub(k, n), tag, out_data, ref_sub(k, n));
      if (rdy) n++;
      stalled = !rdy;
      @(negedge clk);
    end
    out_ready = 1'b0;
    if (limit == NSUB) begin
      chk(done === 1'b1 && out_valid === 1'b0, "R7 done after last",
          {done, out_valid}, 2'b10);
      @(negedge clk);
      chk(done === 1'b0 && out_valid === 1'b0, "R7 single pulse",
          {done, out_valid}, 2'b00);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] rk;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && done === 1'b0, "R1 reset", {out_valid, done}, 2'b00);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0 && done === 1'b0, "R1 after release", {out_valid, done}, 2'b00);

    run_key('0, 0, NSUB);
    run_key('1, 50, NSUB);
    run_key(128'h0001_0002_0003_0004_0005_0006_0007_0008, 0, NSUB);
    run_key(128'h8000_0000_0000_0000_0000_0000_0000_0001, 90, NSUB);

    // R9: ready activity while idle has no effect
    out_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b0 && done === 1'b0, "R9 idle", {out_valid, done}, 2'b00);
    end
    out_ready = 1'b0;

    // R8: restart mid-stream, then a full run with a new key
    rk = {$urandom, $urandom, $urandom, $urandom};
    run_key(rk, 30, 20);
    rk = {$urandom, $urandom, $urandom, $urandom};
    run_key(rk, 30, NSUB);

    for (int t = 0; t < 6; t++) begin
      rk = {$urandom, $urandom, $urandom, $urandom};
      run_key(rk, 10 * t, NSUB);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule